// File: doc/BRIEF.md
# Predict-Taken Branch Redirect Controller

This block steers instruction fetch around conditional and unconditional branches in a five-stage pipeline. The pipeline computes the branch target in decode and resolves the branch condition in execute. The controller always guesses that a branch is taken. When a branch is accepted in decode, it forms the target from the branch address and a scaled, sign-extended displacement. It loads that target into the PC and turns the already-fetched sequential instruction into a bubble. Every branch therefore costs one lost fetch slot, even when the guess is right.

The controller keeps the fall-through address (branch address plus one instruction) beside the branch until execute reports the outcome. If the condition is false, it asserts a flush and reloads the PC with the fall-through address. The flush squashes the wrongly fetched target-path instruction in IF/ID and any instruction sitting in decode, so neither of them changes machine state. A misprediction therefore costs two cycles in total. Unconditional branches are always treated as taken and never flush.

Branches enter through a valid/ready handshake. Ready is low while an earlier branch is still unresolved. While ready is low, the decode stage must hold the branch with its address, displacement and kind unchanged, and the controller freezes fetch. A held branch is dropped, and no longer presented, in the cycle it is flushed. All outputs are combinational from the inputs and one small pending register, so a redirect takes effect at the end of the same cycle.

Top module: `br_taken_unit`

## Requirements
- R1: Out of reset no branch is pending: with no inputs active, dec_br_ready=1, pc_sel=0 (sequential), pc_en=1, and ifid_bubble, id_hold and flush are 0.
- R2: In the cycle a branch is accepted (dec_br_valid and dec_br_ready both 1), pc_sel=1 (target), pc_en=1 and ifid_bubble=1.
- R3: On acceptance, redirect_pc equals dec_pc plus the sign-extended dec_disp shifted left by log2 of the instruction size (2 for 4-byte instructions), modulo 2^AW.
- R4: When execute reports a pending conditional branch with ex_resolve=1 and ex_cond=1, flush stays 0 and fetch continues on the predicted path.
- R5: When execute reports a pending conditional branch with ex_resolve=1 and ex_cond=0, flush=1, pc_sel=2 (fall-through), pc_en=1, and redirect_pc equals that branch's address plus the instruction size, modulo 2^AW.
- R6: For a pending unconditional branch (dec_uncond=1 when accepted), ex_cond is ignored on resolve and flush stays 0.
- R7: While a branch is pending and not being resolved as taken, a presented branch sees dec_br_ready=0, id_hold=1 and pc_en=0. If the pending branch resolves as taken in the same cycle, the presented branch is accepted in that cycle.
- R8: In a mispredict cycle a presented branch is not accepted (dec_br_ready=0) and id_hold=0, because it is being flushed.
- R9: An ex_resolve pulse with no branch pending has no effect: flush=0, and pc_sel stays 0 unless a branch is accepted in that cycle.
- R10: In a cycle with no accepted branch and no flush, pc_sel=0. At most one of flush, ifid_bubble and id_hold is 1 in any cycle.
- R11: dec_br_ready depends only on the pending state and the resolve inputs, never on dec_br_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_br_valid | input | 1 | A branch is in decode with valid fields |
| dec_br_ready | output | 1 | Controller can take the branch this cycle |
| dec_pc | input | AW | Address of the branch in decode |
| dec_disp | input | DW | Signed displacement in instruction units |
| dec_uncond | input | 1 | Branch in decode is unconditional |
| ex_resolve | input | 1 | Execute reports the outcome of the oldest branch |
| ex_cond | input | 1 | Branch condition evaluated in execute (1 = taken) |
| pc_sel | output | 2 | PC source: 0 sequential, 1 target, 2 fall-through |
| pc_en | output | 1 | PC and IF/ID may update this cycle |
| redirect_pc | output | AW | Address to load when pc_sel is nonzero |
| ifid_bubble | output | 1 | Write a NOP into IF/ID instead of the fetched word |
| id_hold | output | 1 | Keep IF/ID, send a NOP into ID/EX |
| flush | output | 1 | Squash IF/ID and the instruction in decode |

## Verification
On every cycle the assertions check three things. First, an accepted branch always selects the target, inserts a bubble and keeps fetch running. Second, a flush only ever accompanies a false resolve, selects the fall-through path and refuses new branches. Third, a hold freezes fetch, and the three pipeline controls never overlap. The bench's scenarios alone show that the computed target and fall-through addresses are numerically right, including negative displacements and wrap at the top of the address space. They also show that an unconditional branch ignores a false condition, and that a held branch is taken in the same cycle its predecessor resolves as taken.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  typedef enum logic [1:0] {
    PCS_SEQ    = 2'd0,
    PCS_TARGET = 2'd1,
    PCS_FALL   = 2'd2
  } pc_sel_e;
endpackage

// File: rtl/bpu_target_adder.sv
// Branch target: base + sign-extended displacement scaled to bytes.
module bpu_target_adder #(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int SH = 2
) (
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] disp,
  output logic [AW-1:0] sum
);
  logic [AW-1:0] ext;

  generate
    if (AW > DW) begin : g_sext
      assign ext = {{(AW-DW){disp[DW-1]}}, disp};
    end else begin : g_trunc
      assign ext = disp[AW-1:0];
    end
  endgenerate

  assign sum = base + (ext << SH);
endmodule

// File: rtl/bpu_pend_track.sv
// Holds the single in-flight branch between decode and execute.
module bpu_pend_track #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_ft,
  input  logic          load_unc,
  input  logic          retire,
  output logic          pend,
  output logic [AW-1:0] pend_ft,
  output logic          pend_unc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      pend_ft  <= '0;
      pend_unc <= 1'b0;
    end else if (load) begin
      pend     <= 1'b1;
      pend_ft  <= load_ft;
      pend_unc <= load_unc;
    end else if (retire) begin
      pend     <= 1'b0;
    end
  end
endmodule

// File: rtl/bpu_redirect_ctrl.sv
// Combinational steering of PC and pipeline registers.
module bpu_redirect_ctrl
  import bpu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          dec_valid,
  input  logic          pend,
  input  logic          pend_unc,
  input  logic [AW-1:0] pend_ft,
  input  logic [AW-1:0] target,
  input  logic          ex_resolve,
  input  logic          ex_cond,
  output logic          ready,
  output logic          accept,
  output logic          retire,
  output logic [1:0]    pc_sel,
  output logic [AW-1:0] redirect,
  output logic          bubble,
  output logic          flush,
  output logic          hold,
  output logic          pc_en
);
  logic resolve_hit, taken_res, mispred;

  always_comb begin
    resolve_hit = ex_resolve && pend;
    taken_res   = resolve_hit && (pend_unc || ex_cond);
    mispred     = resolve_hit && !pend_unc && !ex_cond;
    ready       = !pend || taken_res;
    accept      = dec_valid && ready;
    retire      = resolve_hit;
    flush       = mispred;
    bubble      = accept;
    hold        = dec_valid && !ready && !mispred;
    pc_en       = !hold;
    if (mispred) begin
      pc_sel   = PCS_FALL;
      redirect = pend_ft;
    end else if (accept) begin
      pc_sel   = PCS_TARGET;
      redirect = target;
    end else begin
      pc_sel   = PCS_SEQ;
      redirect = target;
    end
  end
endmodule

// File: rtl/br_taken_unit.sv
module br_taken_unit #(
  parameter int AW         = 32,
  parameter int DW         = 16,
  parameter int INSN_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_br_valid,
  output logic          dec_br_ready,
  input  logic [AW-1:0] dec_pc,
  input  logic [DW-1:0] dec_disp,
  input  logic          dec_uncond,
  input  logic          ex_resolve,
  input  logic          ex_cond,
  output logic [1:0]    pc_sel,
  output logic          pc_en,
  output logic [AW-1:0] redirect_pc,
  output logic          ifid_bubble,
  output logic          id_hold,
  output logic          flush
);
  localparam int            SH   = $clog2(INSN_BYTES);
  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

  logic [AW-1:0] tgt, ft_next, pend_ft;
  logic          pend_q, pend_unc, accept, retire;

  bpu_target_adder #(.AW(AW), .DW(DW), .SH(SH)) u_tgt (
    .base (dec_pc),
    .disp (dec_disp),
    .sum  (tgt)
  );

  assign ft_next = dec_pc + STEP;

  bpu_pend_track #(.AW(AW)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_ft  (ft_next),
    .load_unc (dec_uncond),
    .retire   (retire),
    .pend     (pend_q),
    .pend_ft  (pend_ft),
    .pend_unc (pend_unc)
  );

  bpu_redirect_ctrl #(.AW(AW)) u_ctrl (
    .dec_valid  (dec_br_valid),
    .pend       (pend_q),
    .pend_unc   (pend_unc),
    .pend_ft    (pend_ft),
    .target     (tgt),
    .ex_resolve (ex_resolve),
    .ex_cond    (ex_cond),
    .ready      (dec_br_ready),
    .accept     (accept),
    .retire     (retire),
    .pc_sel     (pc_sel),
    .redirect   (redirect_pc),
    .bubble     (ifid_bubble),
    .flush      (flush),
    .hold       (id_hold),
    .pc_en      (pc_en)
  );
endmodule

// File: rtl/bpu_taken_checker.sv
module bpu_taken_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       dec_br_valid,
  input logic       dec_br_ready,
  input logic [1:0] pc_sel,
  input logic       pc_en,
  input logic       ifid_bubble,
  input logic       id_hold,
  input logic       flush,
  input logic       ex_resolve,
  input logic       ex_cond,
  input logic       pend_q
);
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |-> dec_br_ready);

  p_redirect_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_br_valid && dec_br_ready) |-> (pc_sel == 2'd1 && ifid_bubble && pc_en));

  p_mispredict_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (ex_resolve && !ex_cond && pc_sel == 2'd2 && pc_en && !dec_br_ready));

  p_hold_freezes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    id_hold |-> (!pc_en && !dec_br_ready && !ifid_bubble));

  p_accept_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_br_valid && dec_br_ready) |=> pend_q);

  p_stray_resolve_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_resolve && !pend_q) |-> !flush);

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flush, ifid_bubble, id_hold}));
endmodule

bind br_taken_unit bpu_taken_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dec_br_valid (dec_br_valid),
  .dec_br_ready (dec_br_ready),
  .pc_sel       (pc_sel),
  .pc_en        (pc_en),
  .ifid_bubble  (ifid_bubble),
  .id_hold      (id_hold),
  .flush        (flush),
  .ex_resolve   (ex_resolve),
  .ex_cond      (ex_cond),
  .pend_q       (pend_q)
);

// File: tb/br_taken_unit_tb_top.sv
module br_taken_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_br_valid = 1'b0;
  logic        dec_br_ready;
  logic [31:0] dec_pc = '0;
  logic [15:0] dec_disp = '0;
  logic        dec_uncond = 1'b0;
  logic        ex_resolve = 1'b0;
  logic        ex_cond = 1'b0;
  logic [1:0]  pc_sel;
  logic        pc_en;
  logic [31:0] redirect_pc;
  logic        ifid_bubble;
  logic        id_hold;
  logic        flush;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;
  bit          done = 0;

  // bench-side view of the one outstanding branch
  bit          m_pend = 0;
  logic [31:0] m_ft = '0;
  bit          m_unc = 0;
  bit          last_held = 0;

  always #5 clk = ~clk;

  br_taken_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .dec_br_valid(dec_br_valid), .dec_br_ready(dec_br_ready),
    .dec_pc(dec_pc), .dec_disp(dec_disp), .dec_uncond(dec_uncond),
    .ex_resolve(ex_resolve), .ex_cond(ex_cond),
    .pc_sel(pc_sel), .pc_en(pc_en), .redirect_pc(redirect_pc),
    .ifid_bubble(ifid_bubble), .id_hold(id_hold), .flush(flush)
  );

  function automatic logic [31:0] exp_target(logic [31:0] pc, logic [15:0] d);
    logic signed [31:0] sd;
    sd = 32'($signed(d));
    return pc + 32'(sd * 4);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, logic [31:0] pc, logic [15:0] d, bit u, bit r, bit c);
    bit mis, tk, rdy, acc, hld;
    logic [1:0] sel;
    string t_rdy, t_sel, t_fl;
    @(negedge clk);
    dec_br_valid = v; dec_pc = pc; dec_disp = d; dec_uncond = u;
    ex_resolve = r; ex_cond = c;
    #1;
    mis = r && m_pend && !m_unc && !c;
    tk  = r && m_pend && (m_unc || c);
    rdy = !m_pend || tk;
    acc = v && rdy;
    hld = v && !rdy && !mis;
    sel = mis ? 2'd2 : (acc ? 2'd1 : 2'd0);
    t_rdy = !v ? "R11" : (m_pend ? (mis ? "R8" : "R7") : "R1");
    t_sel = mis ? "R5" : (acc ? "R2" : ((r && !m_pend) ? "R9" : "R10"));
    t_fl  = (r && m_pend && m_unc) ? "R6" : (mis ? "R5" : ((r && !m_pend) ? "R9" : "R4"));
    chk(t_rdy, 32'(dec_br_ready), 32'(rdy));
    chk(t_sel, 32'(pc_sel), 32'(sel));
    chk(t_fl, 32'(flush), 32'(mis));
    chk("R2", 32'(ifid_bubble), 32'(acc));
    chk(mis ? "R8" : "R7", 32'(id_hold), 32'(hld));
    chk("R7", 32'(pc_en), 32'(!hld));
    if (mis) chk("R5", redirect_pc, m_ft);
    else if (acc) chk("R3", redirect_pc, exp_target(pc, d));
    last_held = hld;
    @(posedge clk);
    if (acc) begin m_pend = 1; m_ft = pc + 32'd4; m_unc = u; end
    else if (r && m_pend) m_pend = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    // R1: idle outputs while and after reset
    @(negedge clk); #1;
    chk("R1", 32'(dec_br_ready), 32'd1);
    chk("R1", 32'(pc_sel), 32'd0);
    chk("R1", 32'(flush | ifid_bubble | id_hold), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0);
    // taken conditional: target 0x110, no flush (R2, R3, R4)
    step(1, 32'h100, 16'h0004, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1);
    // not taken, negative displacement: target 0x1FC, fall-through 0x204 (R5)
    step(1, 32'h200, 16'hFFFF, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    // unconditional with false condition (R6)
    step(1, 32'h300, 16'h0010, 1, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    // stray resolve (R9)
    step(0, 0, 0, 0, 1, 0);
    // held branch accepted on taken resolve (R7)
    step(1, 32'h400, 16'h0002, 0, 0, 0);
    step(1, 32'h500, 16'h0003, 0, 0, 0);
    step(1, 32'h500, 16'h0003, 0, 0, 0);
    step(1, 32'h500, 16'h0003, 0, 1, 1);
    step(0, 0, 0, 0, 1, 1);
    // held branch dropped on mispredict (R8)
    step(1, 32'h600, 16'h0001, 0, 0, 0);
    step(1, 32'h700, 16'h0001, 0, 0, 0);
    step(1, 32'h700, 16'h0001, 0, 1, 0);
    // address wrap (R3, R5)
    step(1, 32'hFFFF_FFF0, 16'h0008, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1);
    step(1, 32'hFFFF_FFFC, 16'h8000, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    // constrained random, obeying the hold rule
    begin
      bit v, u, r, c;
      logic [31:0] pc;
      logic [15:0] d;
      v = 0; u = 0; pc = '0; d = '0;
      for (int i = 0; i < 4000; i++) begin
        if (!last_held) begin
          v  = ($urandom_range(99) < 40);
          u  = ($urandom_range(99) < 20);
          pc = $urandom() & 32'hFFFF_FFFC;
          d  = 16'($urandom());
        end
        r = ($urandom_range(99) < 30);
        c = $urandom_range(1) == 1;
        step(v, pc, d, u, r, c);
      end
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_err++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule